// File: doc/BRIEF.md
# SPI Slave Bit Engine with Hold

This block is the bit-level front end of a serial-peripheral slave memory. It runs on a fast system clock and oversamples the bus lines: serial clock, active-low select, serial input and active-low hold. From these samples it finds the bus edges and turns the serial stream into bytes. It also shifts a transmit byte out on the serial output and controls that output's enable. Opcode decoding, storage and write protection are handled by a separate command layer.

The engine learns the bus mode when the select line goes low. An idle-low clock means mode 0 and an idle-high clock means mode 3. From then on, data in is taken on rising clock edges and data out changes on falling clock edges, most significant bit first. After every eighth captured bit the engine issues a one-cycle strobe. The strobe carries the assembled byte and the position of that byte within the current selection.

The command layer answers each strobe by updating the transmit byte. The engine picks up that new byte on the falling clock edge that starts the next byte. A hold input lets the bus master pause a transaction in the middle without losing it. While the hold is in effect, bit progress stops and the output is released. Release the hold and the transaction continues from the point where it stopped.

Top module: `spi_bit_engine`

## Requirements
- R1: The serial clock level seen when the selection begins sets `spi_mode3` (0 = idle low, 1 = idle high), and that value stays fixed for the whole selection.
- R2: In mode 0, serial input bits are captured on rising clock edges, most significant bit first. After the eighth bit, `byte_valid` pulses for exactly one system cycle with the byte on `rx_byte`.
- R3: In mode 3, the falling edge that follows selection neither captures nor shifts anything. The first rising edge after it captures bit 7.
- R4: Bit 7 of the `tx_byte` value present at selection is on `spi_so` before the first rising edge. Each later falling edge shifts the next lower bit onto `spi_so`. The falling edge after the eighth rising edge loads the current `tx_byte` and starts the next byte.
- R5: While the select line is high, `spi_so_oe` is 0 and clock or data activity produces no byte. Deselecting discards a partial byte, and the next byte after reselection has index 0.
- R6: `byte_idx` is 0 for the first byte of a selection and increases by one per byte. It stays at 2^IDX_W-1 once it gets there.
- R7: If hold goes low while the clock is low, `spi_held` rises and `spi_so_oe` drops. Clock edges are then ignored. Once hold returns high with the clock low, bit counting continues at the point where it paused.
- R8: Changes on the select line during a hold are ignored, so a select pulse inside a hold neither ends the transaction nor resets the byte index.
- R9: A hold change made while the clock is high takes effect only once the clock is next low.
- R10: `spi_so_oe` is 1 only while the device is selected, not held, and `tx_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause request |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for the serial data out driver |
| tx_byte | input | DATA_W | Byte to send next, from the command layer |
| tx_en | input | 1 | Command layer asks for the output to be driven |
| rx_byte | output | DATA_W | Most recently assembled byte |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_idx | output | IDX_W | Saturating position of that byte within the selection |
| spi_mode3 | output | 1 | Detected bus mode for the current selection |
| spi_held | output | 1 | A hold is in effect |

## Verification
The bench sends every byte value through long transactions in both modes, checking the received byte, the byte shifted out and the byte index each time. A fault in mode 3 handling would turn up as bytes shifted by one bit. A missing saturation would turn up as the index wrapping back to 0.

The bench deselects in the middle of a byte. A design that kept the partial byte would report a wrong value or a nonzero index on the next byte.

Holds are entered mid-byte while the clock and select line are toggled, and while the clock is high. A design that honoured edges during a hold would corrupt the byte. One that obeyed the select line during a hold would restart the index. One that acted on a hold before the clock went low would drop the output too early.

// File: rtl/spi_be_pkg.sv
package spi_be_pkg;
  typedef struct packed {
    logic sck;
    logic cs_n;
    logic si;
    logic hold_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, cs_n: 1'b1, si: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_be_sync.sv
module spi_be_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_be_ctrl.sv
module spi_be_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic sel,
  output logic sel_start,
  output logic rise_ev,
  output logic fall_ev,
  output logic held,
  output logic mode3
);
  logic sck_q;
  logic sel_d, held_d, mode3_d;

  always_comb begin
    held_d = held;
    if (!sck_s) held_d = !hold_n_s;
    sel_d = sel;
    if (!held) sel_d = !cs_n_s;
  end

  assign sel_start = !sel && sel_d;

  always_comb begin
    mode3_d = mode3;
    if (sel_start) mode3_d = sck_s;
  end

  assign rise_ev = sel && !held &&  sck_s && !sck_q;
  assign fall_ev = sel && !held && !sck_s &&  sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sel   <= 1'b0;
      held  <= 1'b0;
      mode3 <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sel   <= sel_d;
      held  <= held_d;
      mode3 <= mode3_d;
    end
  end

  // R1: mode is frozen for the whole selection
  a_r1_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(mode3));

  // R9: hold state changes only after a low serial clock sample
  a_r9_hold_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (held != $past(held)) |-> !$past(sck_s));

  // R8: selection state does not move while held
  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(sel));
endmodule

// File: rtl/spi_be_shift.sv
module spi_be_shift #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_start,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              si_s,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              so_bit,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic [IDX_W-1:0]  byte_idx
);
  localparam int              CNT_W   = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = {IDX_W{1'b1}};

  logic [CNT_W-1:0]  bit_cnt, bit_cnt_d;
  logic              first, first_d;
  logic [IDX_W-1:0]  idx, idx_d;
  logic [DATA_W-1:0] rx_sh, rx_sh_d, tx_sh, tx_sh_d;
  logic [DATA_W-1:0] rx_out_d;
  logic [IDX_W-1:0]  idx_out_d;
  logic              vld_d;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rx_sh[DATA_W-2:0], si_s};

  always_comb begin
    bit_cnt_d = bit_cnt;
    first_d   = first;
    idx_d     = idx;
    rx_sh_d   = rx_sh;
    tx_sh_d   = tx_sh;
    rx_out_d  = rx_byte;
    idx_out_d = byte_idx;
    vld_d     = 1'b0;
    if (!sel || sel_start) begin
      bit_cnt_d = '0;
      idx_d     = '0;
      first_d   = 1'b1;
      if (sel_start) tx_sh_d = tx_byte;
    end else if (rise_ev) begin
      rx_sh_d   = rx_next;
      bit_cnt_d = bit_cnt + 1'b1;
      first_d   = 1'b0;
      if (bit_cnt == LAST_BIT) begin
        bit_cnt_d = '0;
        vld_d     = 1'b1;
        rx_out_d  = rx_next;
        idx_out_d = idx;
        if (idx != IDX_MAX) idx_d = idx + 1'b1;
      end
    end else if (fall_ev && !first) begin
      if (bit_cnt == '0) tx_sh_d = tx_byte;
      else               tx_sh_d = {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      first      <= 1'b1;
      idx        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_byte    <= '0;
      byte_idx   <= '0;
      byte_valid <= 1'b0;
    end else begin
      bit_cnt    <= bit_cnt_d;
      first      <= first_d;
      idx        <= idx_d;
      rx_sh      <= rx_sh_d;
      tx_sh      <= tx_sh_d;
      rx_byte    <= rx_out_d;
      byte_idx   <= idx_out_d;
      byte_valid <= vld_d;
    end
  end

  assign so_bit = tx_sh[DATA_W-1];

  // R2: a byte strobe lasts one cycle
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R5: bytes only come out of a live selection
  a_r5_valid_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(sel));

  // R6: the index never moves down inside a selection except back to 0 on restart
  a_r6_idx_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel) && !sel_start) |-> (idx >= $past(idx)));
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_en,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic [IDX_W-1:0]  byte_idx,
  output logic              spi_mode3,
  output logic              spi_held
);
  import spi_be_pkg::*;

  logic [1:0] rst_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ns = rst_q[1];

  spi_pins_t pins_raw, pins_s;
  assign pins_raw = '{sck: spi_sck, cs_n: spi_cs_n, si: spi_si, hold_n: spi_hold_n};

  spi_be_sync #(.W($bits(spi_pins_t)), .STAGES(2), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_ns), .d(pins_raw), .q(pins_s)
  );

  logic sel, sel_start, rise_ev, fall_ev;

  spi_be_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_ns),
    .sck_s(pins_s.sck), .cs_n_s(pins_s.cs_n), .hold_n_s(pins_s.hold_n),
    .sel(sel), .sel_start(sel_start), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .held(spi_held), .mode3(spi_mode3)
  );

  spi_be_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk(clk), .rst_n(rst_ns),
    .sel(sel), .sel_start(sel_start), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .si_s(pins_s.si), .tx_byte(tx_byte), .so_bit(spi_so),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .byte_idx(byte_idx)
  );

  assign spi_so_oe = sel && !spi_held && tx_en;

  // R7: no byte completes while a hold is in effect
  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    spi_held |-> !byte_valid);
endmodule

// File: tb/spi_bit_engine_bench.sv
module spi_bit_engine_bench;
  localparam int HP = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sck, cs_n, si, hold_n, tx_en;
  logic [7:0] tx_byte;
  logic so, so_oe, byte_valid, mode3, held;
  logic [7:0] rx_byte;
  logic [3:0] byte_idx;

  spi_bit_engine u_spi_bit_engine (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .tx_byte(tx_byte),
    .tx_en(tx_en), .rx_byte(rx_byte), .byte_valid(byte_valid),
    .byte_idx(byte_idx), .spi_mode3(mode3), .spi_held(held)
  );

  int total = 0, bad = 0;
  int nvalid = 0, in_txn = 0;
  int last_rx = 0, last_idx = 0;

  function automatic logic [7:0] pat(int k);
    return 8'(k * 73 + 29);
  endfunction

  always @(negedge clk) begin
    if (byte_valid) begin
      nvalid   = nvalid + 1;
      last_rx  = int'(rx_byte);
      last_idx = int'(byte_idx);
      in_txn   = in_txn + 1;
      tx_byte  = pat(in_txn);
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select(bit m3);
    sck = m3; tick(4);
    in_txn = 0; tx_byte = pat(0); tick(2);
    cs_n = 1'b0; tick(8);
  endtask

  task automatic deselect(bit m3);
    sck = m3; tick(6);
    cs_n = 1'b1; tick(8);
  endtask

  task automatic bitx(input logic b, output logic so_b);
    sck = 1'b0; si = b; tick(HP);
    so_b = so;
    sck = 1'b1; tick(HP);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) bitx(mo[i], mi[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] mi, mo;
    logic       b;
    int         n0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1;
    tx_en = 1'b1; tx_byte = 8'h00;
    tick(5); rst_n = 1'b1; tick(10);

    check("R10 reset oe", int'(so_oe), 0);
    check("R2 reset valid", int'(byte_valid), 0);
    check("R7 reset held", int'(held), 0);

    // full byte sweep in both modes
    for (int m = 0; m < 2; m++) begin
      select(m[0]);
      check("R1 mode", int'(mode3), m);
      check("R10 oe selected", int'(so_oe), 1);
      for (int k = 0; k < 256; k++) begin
        mo = 8'(k) ^ (m[0] ? 8'h5A : 8'h00);
        n0 = nvalid;
        xfer(mo, mi);
        check(m[0] ? "R3 rx byte mode3" : "R2 rx byte mode0", last_rx, int'(mo));
        check("R2 one strobe", nvalid, n0 + 1);
        check("R6 index", last_idx, (k > 15) ? 15 : k);
        check("R4 tx byte", int'(mi), int'(pat(k)));
      end
      check("R1 mode held", int'(mode3), m);
      deselect(m[0]);
      check("R5 oe idle", int'(so_oe), 0);
    end

    // activity while deselected is ignored
    n0 = nvalid;
    for (int i = 0; i < 8; i++) bitx(1'b1, b);
    sck = 1'b0; tick(6);
    check("R5 no byte when idle", nvalid, n0);
    check("R5 oe idle toggling", int'(so_oe), 0);

    // partial byte discarded on deselect
    select(1'b0);
    n0 = nvalid;
    for (int i = 0; i < 3; i++) bitx(1'b1, b);
    deselect(1'b0);
    select(1'b0);
    xfer(8'hC3, mi);
    check("R5 partial discarded count", nvalid, n0 + 1);
    check("R5 partial discarded value", last_rx, 8'hC3);
    check("R5 index restart", last_idx, 0);
    deselect(1'b0);

    // hold with clock low, clock and select toggling inside
    select(1'b0);
    xfer(8'h11, mi);
    mo = 8'hA6;
    for (int i = 7; i >= 5; i--) bitx(mo[i], mi[i]);
    sck = 1'b0; tick(HP);
    n0 = nvalid;
    hold_n = 1'b0; tick(6);
    check("R7 held", int'(held), 1);
    check("R7 oe off", int'(so_oe), 0);
    for (int i = 0; i < 5; i++) begin
      si = i[0]; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
    end
    cs_n = 1'b1; tick(6); cs_n = 1'b0; tick(6);
    hold_n = 1'b1; tick(6);
    check("R7 released", int'(held), 0);
    check("R7 oe back", int'(so_oe), 1);
    check("R7 no byte in hold", nvalid, n0);
    for (int i = 4; i >= 0; i--) bitx(mo[i], mi[i]);
    check("R7 resumed rx", last_rx, int'(mo));
    check("R7 resumed tx", int'(mi), int'(pat(1)));
    check("R8 index kept", last_idx, 1);

    // hold requested while clock high
    mo = 8'h3C;
    for (int i = 7; i >= 4; i--) bitx(mo[i], mi[i]);
    hold_n = 1'b0; tick(6);
    check("R9 not yet held", int'(held), 0);
    check("R9 oe still on", int'(so_oe), 1);
    sck = 1'b0; tick(6);
    check("R9 held after low", int'(held), 1);
    check("R9 oe off", int'(so_oe), 0);
    hold_n = 1'b1; tick(6);
    check("R9 released", int'(held), 0);
    for (int i = 3; i >= 0; i--) bitx(mo[i], mi[i]);
    check("R9 rx", last_rx, int'(mo));
    check("R9 tx", int'(mi), int'(pat(2)));
    check("R6 index two", last_idx, 2);
    deselect(1'b0);

    // output enable follows tx_en
    tx_en = 1'b0;
    select(1'b1);
    check("R10 oe without tx_en", int'(so_oe), 0);
    check("R1 mode3 again", int'(mode3), 1);
    tx_en = 1'b1; tick(2);
    check("R10 oe with tx_en", int'(so_oe), 1);
    deselect(1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule